// File: doc/BRIEF.md
# Shared interrupt source controller

This block is the programmable front end for a bank of external interrupt sources (64 by default) on a plain 32-bit memory-mapped bus. Each source is brought into the clock domain and conditioned by its own polarity, trigger-mode and dual-edge settings. It is then gated by an enable mask. Finally it is steered by a per-source routing word to one of the output pins, to a non-maskable line, to a yield line, or to any mix of them.

Software enables sources through a set-only register bank and disables them through a clear-only bank. It observes the result through a read-only enable view and a read-only pending view. A write-only command word lets software latch or drop the edge flag of any one source. The block drives its pin outputs, the two special lines and a vector number: the highest active pin plus one, or 0 when no pin is active. All outputs are registered.

Top module: `shic_top`

## Requirements
- R1: After reset, every polarity, trigger, dual-edge, enable and routing field reads 0, every output is 0 and the vector is 0.
- R2: Each per-source bank holds source n at bit (n mod 32) of the word at bank base + (n/32)*4. Bank bases: polarity 0x000, trigger 0x040 (1 = edge, 0 = level), dual-edge 0x080, enable-set 0x0C0, enable-clear 0x100, enable view 0x140, pending view 0x180. Polarity, trigger and dual-edge read back what was written.
- R3: Writing 1 to an enable-set bit enables that source and writing 1 to an enable-clear bit disables it. Bits written as 0 change nothing. Writes to the enable view are ignored, and a set view bit means enabled.
- R4: In level mode a source is pending while its synchronized input XOR its polarity bit is 1. Polarity 1 makes the source active-low.
- R5: In edge mode a 0-to-1 transition of the polarity-corrected input sets the source's edge latch, and the source stays pending after the input returns. Without dual-edge, the opposite transition sets nothing.
- R6: With the dual-edge bit set, an edge-mode source latches on both input transitions.
- R7: A write to the edge command word at 0x1C0 selects the source numbered by bits 15:0. Bit 31 = 1 sets that source's latch and bit 31 = 0 clears it. A number at or above the source count does nothing, and the result shows on the outputs one cycle after the write.
- R8: The pending view shows pending sources whether they are enabled or not. A disabled source drives no output.
- R9: The routing word of source n sits at 0x500 + 4*n, with bit 31 = drive a pin, bit 30 = drive the non-maskable line, bit 29 = drive the yield line, and bits 5:0 = pin number. All other bits read 0. A pin number at or above the pin count drives no pin.
- R10: The vector output equals the highest active pin index plus one, and 0 when no pin is active.
- R11: A level input change reaches the outputs on the third rising clock edge after it is applied. An edge input change reaches them on the fourth.

Parameters: `NUM_SRC` (default 64) and `NUM_PINS` (default 6). `VEC_W` is derived as $clog2(NUM_PINS+1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 16 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| src_i | input | NUM_SRC | Asynchronous interrupt source inputs |
| irq_pin_o | output | NUM_PINS | Combined pin outputs |
| nmi_o | output | 1 | Non-maskable line |
| yield_o | output | 1 | Yield line |
| vec_o | output | VEC_W | Highest active pin plus one, 0 when none |

## Verification
The assertions check the following on every cycle:
- set-only and clear-only enable writes take effect in the next cycle;
- a software latch set always lands;
- an edge latch never drops without a clear command;
- the vector always names the highest active pin;
- the non-maskable line never rises without an enabled pending source.

Only the directed scenarios can show the rest:
- the exact synchronizer latency;
- the polarity inversion;
- single- versus dual-edge capture;
- out-of-range command numbers and pin numbers being ignored;
- the priority between several pins.

// File: rtl/shic_pkg.sv
package shic_pkg;

    localparam logic [15:0] OFS_POL     = 16'h0000;
    localparam logic [15:0] OFS_TRIG    = 16'h0040;
    localparam logic [15:0] OFS_DUAL    = 16'h0080;
    localparam logic [15:0] OFS_ENSET   = 16'h00C0;
    localparam logic [15:0] OFS_ENCLR   = 16'h0100;
    localparam logic [15:0] OFS_ENVIEW  = 16'h0140;
    localparam logic [15:0] OFS_PEND    = 16'h0180;
    localparam logic [15:0] OFS_EDGECMD = 16'h01C0;
    localparam logic [15:0] OFS_ROUTE   = 16'h0500;

    localparam int CMD_NUM_W   = 16;
    localparam int PIN_FIELD_W = 6;

    typedef struct packed {
        logic                   to_pin;
        logic                   to_nmi;
        logic                   to_yield;
        logic [PIN_FIELD_W-1:0] pin;
    } route_t;

    function automatic logic bank_hit(input logic [15:0] a, input logic [15:0] base);
        return a[15:6] == base[15:6];
    endfunction

endpackage

// File: rtl/shic_src_cell.sv
module shic_src_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    input  logic pol_i,
    input  logic trig_i,
    input  logic dual_i,
    input  logic sw_set_i,
    input  logic sw_clr_i,
    output logic pend_o
);

    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
        logic latch;
    } cell_t;

    cell_t st_d, st_q;
    logic  act, prev_act, evt;

    always_comb begin
        st_d     = st_q;
        act      = st_q.s2 ^ pol_i;
        prev_act = st_q.prev ^ pol_i;
        evt      = trig_i & (dual_i ? (st_q.s2 ^ st_q.prev) : (act & ~prev_act));
        st_d.s1    = src_i;
        st_d.s2    = st_q.s1;
        st_d.prev  = st_q.s2;
        st_d.latch = (st_q.latch & ~sw_clr_i) | sw_set_i | evt;
        pend_o     = trig_i ? st_q.latch : act;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_SWSET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        sw_set_i |=> st_q.latch) else $error("software set lost"); // R7

    AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.latch && !sw_clr_i) |=> st_q.latch) else $error("edge latch dropped"); // R5

endmodule

// File: rtl/shic_regs.sv
module shic_regs #(
    parameter int NUM_SRC = 64,
    localparam int W0 = (NUM_SRC < 32) ? NUM_SRC : 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bus_wr,
    input  logic [15:0]                       bus_addr,
    input  logic [31:0]                       bus_wdata,
    output logic [31:0]                       bus_rdata,
    input  logic [NUM_SRC-1:0]                pend_i,
    output logic [NUM_SRC-1:0]                pol_o,
    output logic [NUM_SRC-1:0]                trig_o,
    output logic [NUM_SRC-1:0]                dual_o,
    output logic [NUM_SRC-1:0]                mask_o,
    output shic_pkg::route_t [NUM_SRC-1:0]    route_o,
    output logic [NUM_SRC-1:0]                edge_set_o,
    output logic [NUM_SRC-1:0]                edge_clr_o
);
    import shic_pkg::*;

    typedef struct packed {
        logic [NUM_SRC-1:0]   pol;
        logic [NUM_SRC-1:0]   trig;
        logic [NUM_SRC-1:0]   dual;
        logic [NUM_SRC-1:0]   mask;
        route_t [NUM_SRC-1:0] route;
    } regs_t;

    regs_t       st_d, st_q;
    logic [15:0] roff;
    logic        in_route;
    int unsigned widx, ridx, cmd_num;

    always_comb begin
        roff     = bus_addr - OFS_ROUTE;
        widx     = 32'(bus_addr[5:2]);
        ridx     = 32'(roff[15:2]);
        in_route = (bus_addr >= OFS_ROUTE) && (ridx < NUM_SRC) && (roff[1:0] == 2'b00);
        cmd_num  = 32'(bus_wdata[CMD_NUM_W-1:0]);
    end

    always_comb begin
        st_d       = st_q;
        edge_set_o = '0;
        edge_clr_o = '0;
        if (bus_wr) begin
            for (int n = 0; n < NUM_SRC; n++) begin
                if (widx == n / 32) begin
                    if (bank_hit(bus_addr, OFS_POL))  st_d.pol[n]  = bus_wdata[n % 32];
                    if (bank_hit(bus_addr, OFS_TRIG)) st_d.trig[n] = bus_wdata[n % 32];
                    if (bank_hit(bus_addr, OFS_DUAL)) st_d.dual[n] = bus_wdata[n % 32];
                    if (bank_hit(bus_addr, OFS_ENSET) && bus_wdata[n % 32]) st_d.mask[n] = 1'b1;
                    if (bank_hit(bus_addr, OFS_ENCLR) && bus_wdata[n % 32]) st_d.mask[n] = 1'b0;
                end
                if (in_route && ridx == n) begin
                    st_d.route[n].to_pin   = bus_wdata[31];
                    st_d.route[n].to_nmi   = bus_wdata[30];
                    st_d.route[n].to_yield = bus_wdata[29];
                    st_d.route[n].pin      = bus_wdata[PIN_FIELD_W-1:0];
                end
                if (bank_hit(bus_addr, OFS_EDGECMD) && cmd_num == n) begin
                    edge_set_o[n] = bus_wdata[31];
                    edge_clr_o[n] = ~bus_wdata[31];
                end
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int n = 0; n < NUM_SRC; n++) begin
            if (widx == n / 32) begin
                if (bank_hit(bus_addr, OFS_POL))    bus_rdata[n % 32] = st_q.pol[n];
                if (bank_hit(bus_addr, OFS_TRIG))   bus_rdata[n % 32] = st_q.trig[n];
                if (bank_hit(bus_addr, OFS_DUAL))   bus_rdata[n % 32] = st_q.dual[n];
                if (bank_hit(bus_addr, OFS_ENVIEW)) bus_rdata[n % 32] = st_q.mask[n];
                if (bank_hit(bus_addr, OFS_PEND))   bus_rdata[n % 32] = pend_i[n];
            end
            if (in_route && ridx == n) begin
                bus_rdata[31] = st_q.route[n].to_pin;
                bus_rdata[30] = st_q.route[n].to_nmi;
                bus_rdata[29] = st_q.route[n].to_yield;
                bus_rdata[PIN_FIELD_W-1:0] = st_q.route[n].pin;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pol_o   = st_q.pol;
    assign trig_o  = st_q.trig;
    assign dual_o  = st_q.dual;
    assign mask_o  = st_q.mask;
    assign route_o = st_q.route;

    AST_ENSET_W1S: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_ENSET) |=>
        ((mask_o[W0-1:0] & $past(bus_wdata[W0-1:0])) == $past(bus_wdata[W0-1:0])))
        else $error("enable set failed"); // R3

    AST_ENCLR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_ENCLR) |=>
        ((mask_o[W0-1:0] & $past(bus_wdata[W0-1:0])) == '0))
        else $error("enable clear failed"); // R3

endmodule

// File: rtl/shic_route.sv
module shic_route #(
    parameter int NUM_SRC  = 64,
    parameter int NUM_PINS = 6,
    localparam int VEC_W   = $clog2(NUM_PINS + 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_SRC-1:0]             pend_i,
    input  logic [NUM_SRC-1:0]             mask_i,
    input  shic_pkg::route_t [NUM_SRC-1:0] route_i,
    output logic [NUM_PINS-1:0]            pin_o,
    output logic                           nmi_o,
    output logic                           yield_o,
    output logic [VEC_W-1:0]               vec_o
);

    typedef struct packed {
        logic [NUM_PINS-1:0] pins;
        logic                nmi;
        logic                yld;
        logic [VEC_W-1:0]    vec;
    } out_t;

    out_t               st_d, st_q;
    logic [NUM_SRC-1:0] live;

    always_comb begin
        st_d = '0;
        live = pend_i & mask_i;
        for (int n = 0; n < NUM_SRC; n++) begin
            if (live[n]) begin
                st_d.nmi = st_d.nmi | route_i[n].to_nmi;
                st_d.yld = st_d.yld | route_i[n].to_yield;
                for (int p = 0; p < NUM_PINS; p++) begin
                    if (route_i[n].to_pin && 32'(route_i[n].pin) == p) st_d.pins[p] = 1'b1;
                end
            end
        end
        for (int p = 0; p < NUM_PINS; p++) begin
            if (st_d.pins[p]) st_d.vec = VEC_W'(p + 1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pin_o   = st_q.pins;
    assign nmi_o   = st_q.nmi;
    assign yield_o = st_q.yld;
    assign vec_o   = st_q.vec;

    AST_VEC_IS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pins >> st_q.vec) == '0) else $error("active pin above vector"); // R10

    AST_VEC_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pins == '0) |-> (st_q.vec == '0)) else $error("vector without pin"); // R10

    AST_NMI_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.nmi) |-> $past(|(pend_i & mask_i))) else $error("nmi without source"); // R8

endmodule

// File: rtl/shic_top.sv
module shic_top #(
    parameter int NUM_SRC  = 64,
    parameter int NUM_PINS = 6,
    localparam int VEC_W   = $clog2(NUM_PINS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [15:0]         bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_SRC-1:0]  src_i,
    output logic [NUM_PINS-1:0] irq_pin_o,
    output logic                nmi_o,
    output logic                yield_o,
    output logic [VEC_W-1:0]    vec_o
);

    logic [NUM_SRC-1:0]             pol, trig, dual, mask, pend, e_set, e_clr;
    shic_pkg::route_t [NUM_SRC-1:0] route;

    shic_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pend_i(pend),
        .pol_o(pol), .trig_o(trig), .dual_o(dual), .mask_o(mask),
        .route_o(route), .edge_set_o(e_set), .edge_clr_o(e_clr)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        shic_src_cell u_cell (
            .clk(clk), .rst_n(rst_n), .src_i(src_i[g]), .pol_i(pol[g]),
            .trig_i(trig[g]), .dual_i(dual[g]), .sw_set_i(e_set[g]),
            .sw_clr_i(e_clr[g]), .pend_o(pend[g])
        );
    end

    shic_route #(.NUM_SRC(NUM_SRC), .NUM_PINS(NUM_PINS)) u_route (
        .clk(clk), .rst_n(rst_n), .pend_i(pend), .mask_i(mask), .route_i(route),
        .pin_o(irq_pin_o), .nmi_o(nmi_o), .yield_o(yield_o), .vec_o(vec_o)
    );

endmodule

// File: tb/sim_shic_top.sv
module sim_shic_top;
    localparam int NS = 64;
    localparam int NP = 6;
    localparam int VW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [15:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NS-1:0] src_i = '0;
    logic [NP-1:0] irq_pin;
    logic          nmi, yld;
    logic [VW-1:0] vec;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    shic_top #(.NUM_SRC(NS), .NUM_PINS(NP)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_i(src_i),
        .irq_pin_o(irq_pin), .nmi_o(nmi), .yield_o(yld), .vec_o(vec)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [15:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(req, $sformatf("read 0x%0h", a), bus_rdata, exp);
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_src(input int idx, input logic v);
        @(negedge clk);
        src_i[idx] = v;
    endtask

    task automatic t_reset();
        rd_chk("R1", 16'h0000, 32'h0);
        rd_chk("R1", 16'h0040, 32'h0);
        rd_chk("R1", 16'h0140, 32'h0);
        rd_chk("R1", 16'h050C, 32'h0);
        chk("R1", "pins", 32'(irq_pin), 32'h0);
        chk("R1", "vec", 32'(vec), 32'h0);
        chk("R1", "nmi/yield", {30'b0, nmi, yld}, 32'h0);
    endtask

    task automatic t_level();
        wr(16'h050C, 32'h8000_0002);
        wr(16'h00C0, 32'h0000_0008);
        set_src(3, 1'b1);
        edges(2);
        chk("R11", "level not yet visible", 32'(irq_pin), 32'h0);
        edges(1);
        chk("R4", "level pin", 32'(irq_pin), 32'h4);
        chk("R10", "level vec", 32'(vec), 32'h3);
        rd_chk("R2", 16'h0180, 32'h0000_0008);
        set_src(3, 1'b0);
        edges(3);
        chk("R4", "level released", 32'(irq_pin), 32'h0);
        wr(16'h0000, 32'h0000_0008);
        edges(1);
        chk("R4", "active-low pending", 32'(irq_pin), 32'h4);
        rd_chk("R2", 16'h0000, 32'h0000_0008);
        wr(16'h0000, 32'h0);
        edges(1);
        chk("R4", "polarity restored", 32'(irq_pin), 32'h0);
    endtask

    task automatic t_mask();
        wr(16'h00C0, 32'h0);
        rd_chk("R3", 16'h0140, 32'h0000_0008);
        wr(16'h0100, 32'h0000_0001);
        rd_chk("R3", 16'h0140, 32'h0000_0008);
        wr(16'h0140, 32'hFFFF_FFFF);
        rd_chk("R3", 16'h0140, 32'h0000_0008);
        wr(16'h0100, 32'h0000_0008);
        rd_chk("R3", 16'h0140, 32'h0);
        set_src(3, 1'b1);
        edges(4);
        chk("R8", "disabled source silent", 32'(irq_pin), 32'h0);
        rd_chk("R8", 16'h0180, 32'h0000_0008);
        set_src(3, 1'b0);
        wr(16'h00C4, 32'h0000_0100);
        rd_chk("R2", 16'h0144, 32'h0000_0100);
        rd_chk("R2", 16'h0140, 32'h0);
    endtask

    task automatic t_edge();
        wr(16'h0044, 32'h0000_0100);
        wr(16'h05A0, 32'h8000_0005);
        edges(3);
        set_src(40, 1'b1);
        edges(3);
        chk("R11", "edge not yet visible", 32'(irq_pin), 32'h0);
        edges(1);
        chk("R5", "edge pin", 32'(irq_pin), 32'h20);
        chk("R10", "edge vec", 32'(vec), 32'h6);
        set_src(40, 1'b0);
        edges(4);
        chk("R5", "edge held", 32'(irq_pin), 32'h20);
        rd_chk("R2", 16'h0184, 32'h0000_0100);
        wr(16'h01C0, 32'd40);
        edges(1);
        chk("R7", "cleared by command", 32'(irq_pin), 32'h0);
        set_src(40, 1'b1);
        edges(5);
        wr(16'h01C0, 32'd40);
        edges(1);
        chk("R7", "cleared while high", 32'(irq_pin), 32'h0);
        set_src(40, 1'b0);
        edges(5);
        chk("R5", "falling ignored", 32'(irq_pin), 32'h0);
    endtask

    task automatic t_dual();
        wr(16'h0084, 32'h0000_0100);
        rd_chk("R2", 16'h0084, 32'h0000_0100);
        set_src(40, 1'b1);
        edges(5);
        chk("R6", "dual rising", 32'(irq_pin), 32'h20);
        wr(16'h01C0, 32'd40);
        edges(1);
        chk("R6", "dual cleared", 32'(irq_pin), 32'h0);
        set_src(40, 1'b0);
        edges(5);
        chk("R6", "dual falling", 32'(irq_pin), 32'h20);
        wr(16'h01C0, 32'd40);
        wr(16'h0084, 32'h0);
        edges(1);
        chk("R6", "dual off", 32'(irq_pin), 32'h0);
    endtask

    task automatic t_cmd();
        wr(16'h01C0, 32'h8000_0028);
        edges(1);
        chk("R7", "command set", 32'(irq_pin), 32'h20);
        rd_chk("R7", 16'h0184, 32'h0000_0100);
        wr(16'h01C0, 32'h0000_0028);
        edges(1);
        chk("R7", "command clear", 32'(irq_pin), 32'h0);
        wr(16'h01C0, 32'h8000_0064);
        edges(1);
        chk("R7", "out-of-range number", 32'(irq_pin), 32'h0);
        rd_chk("R7", 16'h0180, 32'h0);
        rd_chk("R7", 16'h0184, 32'h0);
    endtask

    task automatic t_route();
        wr(16'h050C, 32'h6000_FF00);
        rd_chk("R9", 16'h050C, 32'h6000_0000);
        wr(16'h00C0, 32'h0000_0008);
        set_src(3, 1'b1);
        edges(3);
        chk("R9", "nmi+yield", {30'b0, nmi, yld}, 32'h3);
        chk("R9", "no pin", 32'(irq_pin), 32'h0);
        chk("R10", "no vec", 32'(vec), 32'h0);
        wr(16'h050C, 32'h8000_0007);
        edges(1);
        chk("R9", "pin out of range", 32'(irq_pin), 32'h0);
        chk("R9", "nmi dropped", {30'b0, nmi, yld}, 32'h0);
        rd_chk("R9", 16'h050C, 32'h8000_0007);
    endtask

    task automatic t_prio();
        wr(16'h050C, 32'h8000_0002);
        edges(1);
        chk("R10", "single pin vec", 32'(vec), 32'h3);
        wr(16'h01C0, 32'h8000_0028);
        edges(1);
        chk("R10", "two pins", 32'(irq_pin), 32'h24);
        chk("R10", "highest wins", 32'(vec), 32'h6);
        wr(16'h050C, 32'h8000_0000);
        edges(1);
        chk("R10", "pin 0 and 5", 32'(irq_pin), 32'h21);
        wr(16'h01C0, 32'h0000_0028);
        edges(1);
        chk("R10", "pin 0 only vec", 32'(vec), 32'h1);
        set_src(3, 1'b0);
        edges(3);
        chk("R10", "idle vec", 32'(vec), 32'h0);
    endtask

    initial begin
        #(8 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        edges(3);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_level();
        t_mask();
        t_edge();
        t_dual();
        t_cmd();
        t_route();
        t_prio();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule